// File: doc/BRIEF.md
# Coil Driver Operating-Mode Controller

This block decides the operating mode of a voice-coil driver: shutdown, standby or active. A host can force shutdown without a register write by holding the two-wire bus clock low for a timed interval. The block watches that clock level and counts microsecond ticks while it stays low. When the clock returns high after a shutdown, the block moves to standby and asks the register file to reload its default values.

From standby it enables the coil output stage once the coil current register holds a nonzero value and no fault is being reported. It falls back to standby when that register returns to zero, when software requests a register reset, or when a fault is flagged. On a fault it also issues a pulse that clears the current register. Fault flags are latched into a status vector. The status is wiped when the block next enters active and when defaults are loaded. Fault detection circuits sit outside this block.

Top module: `coil_mode_ctrl`

## Requirements
- R1: After reset the mode output is standby (2'b01), the output-stage enable and all three pulse outputs are low, and the fault status is zero.
- R2: When the synchronised clock line has been low across SHUT_US consecutive tick pulses, the mode becomes shutdown (2'b00) within a few cycles. After SHUT_US-1 ticks the mode is unchanged.
- R3: The low-interval count restarts whenever the clock line is seen high. Ticks that arrive while the line is high are not counted.
- R4: Shutdown holds for as long as the clock line stays low. The current-zero flag and the software reset input have no effect in shutdown, and no pulse is issued there.
- R5: A high level on the clock line in shutdown moves the mode to standby and issues exactly one default-load pulse.
- R6: In standby with current nonzero, no fault input and no pending clear, the mode becomes active (2'b10) at the next edge, with a one-cycle status-clear pulse. In active with current zero, the mode returns to standby.
- R7: A fault input in active (bit 0 over-temperature, bit 1 coil short, bit 2 coil open) returns the mode to standby at the next edge, with a one-cycle current-clear pulse.
- R8: Each fault input bit sets the matching status bit at the next edge. The bit holds until the mode enters active or defaults are loaded.
- R9: A fault input present in standby keeps the mode in standby.
- R10: A software reset in standby or active issues one default-load pulse and leaves the mode in standby.
- R11: After a default-load or current-clear pulse, activation is held off until the current-zero flag has been seen high.
- R12: The output-stage enable is high exactly while the mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw level of the bus clock line |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cur_is_zero | input | 1 | Coil current register holds zero |
| sw_reset | input | 1 | Software register-reset request |
| fault_in | input | NUM_FAULTS | Fault flags: over-temperature, short, open |
| mode_o | output | 2 | 00 shutdown, 01 standby, 10 active |
| drv_en_o | output | 1 | Output-stage enable |
| load_dflt_o | output | 1 | Pulse: load register defaults |
| cur_clr_o | output | 1 | Pulse: clear coil current register |
| stat_clr_o | output | 1 | Pulse: fault status cleared |
| fault_stat_o | output | NUM_FAULTS | Latched fault status |

## Verification
The hardest condition to reach from the ports is the exact boundary of the low-clock interval. The mode must not change after one tick less than the limit, and it must change after the limit is reached, with the clock synchroniser adding latency on the way. The bench holds the line low, waits out the synchroniser, and issues tick pulses one at a time. It checks the mode one tick short of the limit and again one tick after. It also breaks a long low run with a short high spell that carries stray ticks, to show that the count starts over. The pending-clear interlock is reached by following a fault or reset pulse with a nonzero current flag, so that the mode is seen to stay in standby until the flag drops to zero once.

// File: rtl/coil_mode_pkg.sv
package coil_mode_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_IDLE = 2'b01,
      MODE_RUN  = 2'b10
   } drv_mode_e;
endpackage

// File: rtl/scl_low_timer.sv
// Synchronises the bus clock level and measures how long it stays low.
module scl_low_timer #(
   parameter int SHUT_US     = 500,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic us_tick,
   output logic scl_s,
   output logic long_low
);
   localparam int CNT_W = $clog2(SHUT_US + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SHUT_US);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign scl_s = scl_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '1;
            else        sr_q <= (sr_q << 1) | SYNC_STAGES'(scl_in);
         end
         assign scl_s = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (scl_s)                    cnt_q <= '0;
      else if (us_tick && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign long_low = (cnt_q == LIMIT) && !scl_s;
endmodule

// File: rtl/fault_latch.sv
// Sticky fault status; new faults win over a clear in the same cycle.
module fault_latch #(
   parameter int NUM_FAULTS = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_FAULTS-1:0] fault_in,
   input  logic                  clr,
   output logic [NUM_FAULTS-1:0] stat,
   output logic                  any_fault
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (clr ? '0 : stat) | fault_in;
   end

   assign any_fault = |fault_in;
endmodule

// File: rtl/mode_fsm.sv
// Three-state mode sequencer with registered pulse outputs.
module mode_fsm
   import coil_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      scl_s,
   input  logic      long_low,
   input  logic      cur_is_zero,
   input  logic      sw_reset,
   input  logic      any_fault,
   output drv_mode_e state,
   output logic      load_q,
   output logic      cclr_q,
   output logic      sclr_q,
   output logic      go_load,
   output logic      go_run
);
   drv_mode_e nxt;
   logic      go_cclr;
   logic      pend_q;

   always_comb begin
      nxt     = state;
      go_load = 1'b0;
      go_cclr = 1'b0;
      go_run  = 1'b0;
      if (long_low) begin
         nxt = MODE_OFF;
      end else begin
         case (state)
            MODE_OFF: begin
               if (scl_s) begin
                  nxt     = MODE_IDLE;
                  go_load = 1'b1;
               end
            end
            MODE_RUN: begin
               if (sw_reset) begin
                  nxt     = MODE_IDLE;
                  go_load = 1'b1;
               end else if (any_fault) begin
                  nxt     = MODE_IDLE;
                  go_cclr = 1'b1;
               end else if (cur_is_zero) begin
                  nxt = MODE_IDLE;
               end
            end
            default: begin
               if (sw_reset) begin
                  nxt     = MODE_IDLE;
                  go_load = 1'b1;
               end else if (!cur_is_zero && !any_fault && !pend_q) begin
                  nxt    = MODE_RUN;
                  go_run = 1'b1;
               end else begin
                  nxt = MODE_IDLE;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= MODE_IDLE;
         load_q <= 1'b0;
         cclr_q <= 1'b0;
         sclr_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         state  <= nxt;
         load_q <= go_load;
         cclr_q <= go_cclr;
         sclr_q <= go_run;
         if (go_load || go_cclr) pend_q <= 1'b1;
         else if (cur_is_zero)   pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/coil_mode_ctrl.sv
module coil_mode_ctrl
   import coil_mode_pkg::*;
#(
   parameter int SHUT_US     = 500,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_FAULTS  = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  us_tick,
   input  logic                  cur_is_zero,
   input  logic                  sw_reset,
   input  logic [NUM_FAULTS-1:0] fault_in,
   output logic [1:0]            mode_o,
   output logic                  drv_en_o,
   output logic                  load_dflt_o,
   output logic                  cur_clr_o,
   output logic                  stat_clr_o,
   output logic [NUM_FAULTS-1:0] fault_stat_o
);
   generate
      if (SHUT_US < 1) begin : g_bad_shut
         $error("SHUT_US must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
      if (NUM_FAULTS < 1) begin : g_bad_flt
         $error("NUM_FAULTS must be at least 1");
      end
   endgenerate

   logic      scl_s;
   logic      long_low;
   logic      any_fault;
   logic      go_load;
   logic      go_run;
   drv_mode_e state;

   scl_low_timer #(.SHUT_US(SHUT_US), .SYNC_STAGES(SYNC_STAGES)) u_timer (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .us_tick(us_tick),
      .scl_s(scl_s), .long_low(long_low)
   );

   fault_latch #(.NUM_FAULTS(NUM_FAULTS)) u_flt (
      .clk(clk), .rst_n(rst_n), .fault_in(fault_in),
      .clr(go_load | go_run), .stat(fault_stat_o), .any_fault(any_fault)
   );

   mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .long_low(long_low),
      .cur_is_zero(cur_is_zero), .sw_reset(sw_reset), .any_fault(any_fault),
      .state(state), .load_q(load_dflt_o), .cclr_q(cur_clr_o),
      .sclr_q(stat_clr_o), .go_load(go_load), .go_run(go_run)
   );

   assign mode_o   = state;
   assign drv_en_o = (state == MODE_RUN);
endmodule

// File: rtl/coil_mode_ctrl_chk.sv
module coil_mode_ctrl_chk #(
   parameter int NUM_FAULTS = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  long_low,
   input logic [NUM_FAULTS-1:0] fault_in,
   input logic [1:0]            mode_o,
   input logic                  drv_en_o,
   input logic                  load_dflt_o,
   input logic                  cur_clr_o,
   input logic                  stat_clr_o,
   input logic [NUM_FAULTS-1:0] fault_stat_o
);
   assert_off_needs_long_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'b00 && !long_low) |=> mode_o != 2'b00);

   assert_off_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && !scl_s) |=> (mode_o == 2'b00 && !load_dflt_o));

   assert_wake_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01 && $past(mode_o) == 2'b00) |-> load_dflt_o);

   assert_fault_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b10 && |fault_in && !long_low) |=> (!drv_en_o && cur_clr_o));

   assert_status_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr_o |-> fault_stat_o == '0);

   assert_fault_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01 && |fault_in) |=> mode_o != 2'b10);

   assert_run_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en_o) |-> stat_clr_o);

   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_dflt_o, cur_clr_o, stat_clr_o}));
endmodule

bind coil_mode_ctrl coil_mode_ctrl_chk #(.NUM_FAULTS(NUM_FAULTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .long_low(long_low),
   .fault_in(fault_in), .mode_o(mode_o), .drv_en_o(drv_en_o),
   .load_dflt_o(load_dflt_o), .cur_clr_o(cur_clr_o),
   .stat_clr_o(stat_clr_o), .fault_stat_o(fault_stat_o)
);

// File: tb/coil_mode_ctrl_test.sv
module coil_mode_ctrl_test;
   localparam int SHUT_US = 500;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1;
   logic       us_tick = 1'b0;
   logic       cur_is_zero = 1'b1;
   logic       sw_reset = 1'b0;
   logic [2:0] fault_in = 3'b000;
   logic [1:0] mode_o;
   logic       drv_en_o, load_dflt_o, cur_clr_o, stat_clr_o;
   logic [2:0] fault_stat_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   coil_mode_ctrl #(.SHUT_US(SHUT_US), .SYNC_STAGES(2), .NUM_FAULTS(3)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .us_tick(us_tick),
      .cur_is_zero(cur_is_zero), .sw_reset(sw_reset), .fault_in(fault_in),
      .mode_o(mode_o), .drv_en_o(drv_en_o), .load_dflt_o(load_dflt_o),
      .cur_clr_o(cur_clr_o), .stat_clr_o(stat_clr_o),
      .fault_stat_o(fault_stat_o)
   );

   // {cz, fault[2:0], sw, mode[1:0], en, load, cclr, sclr, stat[2:0]}
   localparam logic [13:0] VEC [0:17] = '{
      14'b1_000_0_01_0_0_0_0_000,  // R1 idle
      14'b0_000_0_10_1_0_0_1_000,  // R6 activate
      14'b0_000_0_10_1_0_0_0_000,  // R12 hold
      14'b1_000_0_01_0_0_0_0_000,  // R6 zero -> standby
      14'b0_000_0_10_1_0_0_1_000,  // R6
      14'b0_001_0_01_0_0_1_0_001,  // R7 over-temp
      14'b0_000_0_01_0_0_0_0_001,  // R11 pending
      14'b1_000_0_01_0_0_0_0_001,  // R11 release
      14'b1_010_0_01_0_0_0_0_011,  // R8 latch short
      14'b0_010_0_01_0_0_0_0_011,  // R9 blocked
      14'b0_000_0_10_1_0_0_1_000,  // R8 cleared on entry
      14'b0_000_1_01_0_1_0_0_000,  // R10 sw reset
      14'b0_000_0_01_0_0_0_0_000,  // R11 pending
      14'b1_000_0_01_0_0_0_0_000,  // R11 release
      14'b0_100_0_01_0_0_0_0_100,  // R9 open in standby
      14'b0_000_0_10_1_0_0_1_000,  // R6
      14'b0_100_0_01_0_0_1_0_100,  // R7 open
      14'b1_000_0_01_0_0_0_0_100   // R8 hold
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         us_tick = 1'b1;
         @(negedge clk);
         us_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int lp;
      cycles(4);
      rst_n = 1'b1;
      cycles(1);
      check("R1 reset", {fault_stat_o, mode_o, drv_en_o, load_dflt_o, cur_clr_o, stat_clr_o},
            {3'b000, 2'b01, 4'b0000});

      for (int v = 0; v < 18; v++) begin
         cur_is_zero = VEC[v][13];
         fault_in    = VEC[v][12:10];
         sw_reset    = VEC[v][9];
         @(negedge clk);
         check($sformatf("vector %0d (R6..R12)", v),
               {mode_o, drv_en_o, load_dflt_o, cur_clr_o, stat_clr_o, fault_stat_o},
               VEC[v][8:0]);
      end
      fault_in = 3'b000;
      sw_reset = 1'b0;

      // R2: boundary of the low interval, entered from active
      cur_is_zero = 1'b0;
      cycles(2);
      check("R12 active before shutdown", drv_en_o, 1'b1);
      scl_in = 1'b0;
      cycles(4);
      ticks(SHUT_US - 1);
      cycles(3);
      check("R2 one tick short", mode_o, 2'b10);
      ticks(1);
      cycles(3);
      check("R2 shutdown reached", mode_o, 2'b00);
      check("R12 enable off in shutdown", drv_en_o, 1'b0);

      // R4: inputs ignored while line low
      lp = 0;
      sw_reset = 1'b1;
      cur_is_zero = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         lp += load_dflt_o;
      end
      sw_reset = 1'b0;
      check("R4 stays off", mode_o, 2'b00);
      check("R4 no load pulse", lp, 0);

      // R5: wake with exactly one load pulse
      scl_in = 1'b1;
      lp = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         lp += load_dflt_o;
      end
      check("R5 standby after wake", mode_o, 2'b01);
      check("R5 one load pulse", lp, 1);
      check("R11 held after load", mode_o, 2'b01);
      cur_is_zero = 1'b1;
      cycles(1);
      cur_is_zero = 1'b0;
      cycles(2);
      check("R11 released", mode_o, 2'b10);

      // R3: count restart
      cur_is_zero = 1'b1;
      cycles(2);
      scl_in = 1'b0;
      cycles(4);
      ticks(300);
      scl_in = 1'b1;
      cycles(4);
      ticks(50);
      scl_in = 1'b0;
      cycles(4);
      ticks(300);
      cycles(3);
      check("R3 count restarted", mode_o, 2'b01);
      ticks(SHUT_US - 300);
      cycles(3);
      check("R3 shutdown after full run", mode_o, 2'b00);
      scl_in = 1'b1;
      cycles(6);
      check("R5 back to standby", mode_o, 2'b01);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule